// File: doc/BRIEF.md
# Montgomery Modular Multiplier with a Single Configurable Carry-Save Level

This block computes the Montgomery product A·B·2^-K mod N for K-bit binary operands and an odd modulus N. The caller presents A, B and N on plain binary inputs with a one-cycle start pulse. After an internal run the block drives the reduced binary product on `result` and raises `done` for one cycle. No redundant-form value ever appears at the ports.

Inside there is exactly one level of bit cells, and each cell can act as a full adder or as two half adders in series. The same array serves three phases. First it forms B+N by repeated carry-save passes. Then it runs the radix-2 iterations, where each step adds one of {0, B, N, B+N} and shifts the sum and carry right. Finally it turns the sum/carry pair back into binary by more passes until the carry word is zero. The pre-computation and conversion phases run two half-adder passes per cycle. A quotient detector works out the current quotient bit and the next one from the low bits of the redundant state. When two iterations in a row would both add zero, it folds them into a single cycle on the half-adder path. A single conditional subtraction of N brings the result below N.

Top module: `montmul_ccsa`

## Requirements
- R1: For odd N with 3 ≤ N < 2^K and A, B < N, the value on `result` while `done` is high equals A·B·2^-K mod N and is less than N.
- R2: `done` is high for exactly one cycle per accepted start. `result` keeps its value until the next multiplication completes.
- R3: A start pulse that arrives while a multiplication is in progress is ignored. The running operation completes with its own operands, and no second `done` follows.
- R4: `done` rises no more than 2K+6 clock cycles after the clock edge that samples `start`. The iteration counter never exceeds K.
- R5: When every iteration would add zero (A=0 and B=0), iterations are taken two per cycle. `done` then rises within K/2+4 cycles of the start edge.
- R6: Edge operands are handled exactly. A=0 or B=0 gives 0, and A=B=N-1 gives (N-1)^2·2^-K mod N.
- R7: After reset, `done` is low and `result` is zero.
- R8: Conversion back to binary ends only when the carry word is zero. Every iteration step leaves an even pre-shift sum, so no set bit is lost by the right shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| a_in | input | K | Multiplier operand A, binary |
| b_in | input | K | Multiplicand operand B, binary |
| n_in | input | K | Odd modulus N, binary |
| result | output | K | Montgomery product, binary, held until the next completion |
| done | output | 1 | One-cycle pulse when `result` is new |

## Verification
The hardest behaviour to reach from the ports is the folded double iteration. It only happens when the current and the next quotient bits are both zero and both multiplier bits are zero, and it is only visible as a change in latency. The stimulus runs A=0, B=0 against several moduli and measures the cycles to `done` against the K/2+4 bound. The general runs are timed against 2K+6. An in-flight second start with different operands shows that the latched operands cannot be overwritten.

// File: rtl/montmul_pkg.sv
package montmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ITER,
    ST_CONV
  } mm_state_e;

  typedef enum logic [1:0] {
    CM_FULL,          // one three-input carry-save add, then shift
    CM_HALF2_SHIFT,   // two zero-addend steps, each with a shift
    CM_HALF2_RESOLVE  // two carry-resolve passes, no shift
  } cell_mode_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic ha_sum(input logic x, input logic y);
    return x ^ y;
  endfunction

  function automatic logic ha_carry(input logic x, input logic y);
    return x & y;
  endfunction

endpackage

// File: rtl/montmul_cell_array.sv
module montmul_cell_array
  import montmul_pkg::*;
#(
  parameter int W = 18
) (
  input  cell_mode_e     mode,
  input  logic [W-1:0]   s_i,
  input  logic [W-1:0]   c_i,
  input  logic [W-1:0]   x_i,
  output logic [W-1:0]   s_o,
  output logic [W-1:0]   c_o,
  output logic           low_bit
);

  logic [W-1:0] fs, fc, h1s, h1c;
  logic [W-1:0] u, v, u2s, u2c;
  logic [W-1:0] p1c, r2s, r2c;

  // first level: every cell provides both the full-adder and half-adder view
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign fs[i]  = fa_sum(s_i[i], c_i[i], x_i[i]);
    assign fc[i]  = fa_carry(s_i[i], c_i[i], x_i[i]);
    assign h1s[i] = ha_sum(s_i[i], c_i[i]);
    assign h1c[i] = ha_carry(s_i[i], c_i[i]);
  end

  // second half adder of each cell, two wirings
  assign u   = h1s >> 1;
  assign v   = h1c;
  assign p1c = {h1c[W-2:0], 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_second
    assign u2s[i] = ha_sum(u[i], v[i]);
    assign u2c[i] = ha_carry(u[i], v[i]);
    assign r2s[i] = ha_sum(h1s[i], p1c[i]);
    assign r2c[i] = ha_carry(h1s[i], p1c[i]);
  end

  always_comb begin
    unique case (mode)
      CM_FULL: begin
        s_o     = fs >> 1;
        c_o     = fc;
        low_bit = fs[0];
      end
      CM_HALF2_SHIFT: begin
        s_o     = u2s >> 1;
        c_o     = u2c;
        low_bit = h1s[0] | u2s[0];
      end
      default: begin
        s_o     = r2s;
        c_o     = {r2c[W-2:0], 1'b0};
        low_bit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/montmul_qdetect.sv
module montmul_qdetect (
  input  logic [1:0] s_lo,
  input  logic [1:0] c_lo,
  input  logic       a_cur,
  input  logic       a_nxt,
  input  logic       b0,
  input  logic       has_next,
  output logic       q_cur,
  output logic       skip
);

  logic zero_now, q_nxt;

  assign q_cur    = s_lo[0] ^ c_lo[0] ^ (a_cur & b0);
  assign zero_now = ~a_cur & ~q_cur;
  // low bit after a zero-addend step: (S^C)>>1 plus S&C
  assign q_nxt    = s_lo[1] ^ c_lo[1] ^ (s_lo[0] & c_lo[0]) ^ (a_nxt & b0);
  assign skip     = zero_now & has_next & ~a_nxt & ~q_nxt;

endmodule

// File: rtl/montmul_ccsa.sv
module montmul_ccsa
  import montmul_pkg::*;
#(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] b_in,
  input  logic [K-1:0] n_in,
  output logic [K-1:0] result,
  output logic         done
);

  localparam int W  = K + 2;
  localparam int CW = $clog2(K + 1);

  mm_state_e    state;
  logic [K-1:0] a_q;
  logic [W-1:0] b_q, n_q, d_q, s_q, c_q;
  logic [CW-1:0] cnt;
  logic [K-1:0] result_q;
  logic         done_q;

  // named internal events
  logic         busy, iterating, carry_clear, skip, skip_raw, q_cur, has_next, low_bit;
  logic [W-1:0] addend, cell_x, cell_s, cell_c, reduced;
  logic [CW-1:0] step, cnt_nxt;
  cell_mode_e   cell_mode;

  assign busy        = (state != ST_IDLE);
  assign iterating   = (state == ST_ITER);
  assign carry_clear = (c_q == '0);
  assign has_next    = (cnt != CW'(K - 1));
  assign skip        = skip_raw & iterating;
  assign step        = skip ? CW'(2) : CW'(1);
  assign cnt_nxt     = cnt + step;

  montmul_qdetect u_qdet (
    .s_lo     (s_q[1:0]),
    .c_lo     (c_q[1:0]),
    .a_cur    (a_q[0]),
    .a_nxt    (a_q[1]),
    .b0       (b_q[0]),
    .has_next (has_next),
    .q_cur    (q_cur),
    .skip     (skip_raw)
  );

  always_comb begin
    unique case ({a_q[0], q_cur})
      2'b00:   addend = '0;
      2'b10:   addend = b_q;
      2'b01:   addend = n_q;
      default: addend = d_q;
    endcase
  end

  always_comb begin
    if (iterating) begin
      cell_mode = skip ? CM_HALF2_SHIFT : CM_FULL;
      cell_x    = addend;
    end else begin
      cell_mode = CM_HALF2_RESOLVE;
      cell_x    = '0;
    end
  end

  montmul_cell_array #(.W(W)) u_cells (
    .mode    (cell_mode),
    .s_i     (s_q),
    .c_i     (c_q),
    .x_i     (cell_x),
    .s_o     (cell_s),
    .c_o     (cell_c),
    .low_bit (low_bit)
  );

  assign reduced = (s_q >= n_q) ? (s_q - n_q) : s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      n_q      <= '0;
      d_q      <= '0;
      s_q      <= '0;
      c_q      <= '0;
      cnt      <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            a_q   <= a_in;
            b_q   <= {{(W-K){1'b0}}, b_in};
            n_q   <= {{(W-K){1'b0}}, n_in};
            s_q   <= {{(W-K){1'b0}}, b_in};
            c_q   <= {{(W-K){1'b0}}, n_in};
            state <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (carry_clear) begin
            d_q   <= s_q;
            s_q   <= '0;
            c_q   <= '0;
            cnt   <= '0;
            state <= ST_ITER;
          end else begin
            s_q <= cell_s;
            c_q <= cell_c;
          end
        end
        ST_ITER: begin
          s_q <= cell_s;
          c_q <= cell_c;
          a_q <= skip ? (a_q >> 2) : (a_q >> 1);
          cnt <= cnt_nxt;
          if (cnt_nxt == CW'(K)) state <= ST_CONV;
        end
        default: begin
          if (carry_clear) begin
            result_q <= reduced[K-1:0];
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            s_q <= cell_s;
            c_q <= cell_c;
          end
        end
      endcase
    end
  end

  assign result = result_q;
  assign done   = done_q;

endmodule

// File: rtl/montmul_sva.sv
module montmul_sva #(
  parameter int K  = 16,
  parameter int W  = K + 2,
  parameter int CW = $clog2(K + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [K-1:0]  result,
  input logic [W-1:0]  n_q,
  input logic [W-1:0]  c_q,
  input logic [W-1:0]  addend,
  input logic [CW-1:0] cnt,
  input logic          busy,
  input logic          iterating,
  input logic          skip,
  input logic          low_bit
);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < n_q[K-1:0]));

  a_r8_even_before_shift: assert property (@(posedge clk) disable iff (!rst_n)
    iterating |-> !low_bit);

  a_r8_carry_clear_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (c_q == '0));

  a_r5_skip_zero_addend: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (addend == '0));

  a_r3_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(n_q));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(K));

endmodule

bind montmul_ccsa montmul_sva #(.K(K)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .result    (result),
  .n_q       (n_q),
  .c_q       (c_q),
  .addend    (addend),
  .cnt       (cnt),
  .busy      (busy),
  .iterating (iterating),
  .skip      (skip),
  .low_bit   (low_bit)
);

// File: tb/montmul_ccsa_tb.sv
module montmul_ccsa_tb;

  localparam int K = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] a_in = '0, b_in = '0, n_in = '0;
  logic [K-1:0] result;
  logic         done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  montmul_ccsa #(.K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .n_in(n_in),
    .result(result), .done(done)
  );

  // modular product, then K modular halvings
  function automatic longint unsigned ref_mm(longint unsigned a, longint unsigned b,
                                             longint unsigned n);
    longint unsigned x;
    x = (a * b) % n;
    for (int i = 0; i < K; i++) x = x[0] ? (x + n) >> 1 : x >> 1;
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // start on a negedge; lat counts edges after the start edge until done is seen
  task automatic run_op(input logic [K-1:0] a, input logic [K-1:0] b,
                        input logic [K-1:0] n, output logic [K-1:0] res,
                        output int lat);
    @(negedge clk);
    a_in = a; b_in = b; n_in = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  task automatic t_one(input logic [K-1:0] a, input logic [K-1:0] b,
                       input logic [K-1:0] n, input string req);
    logic [K-1:0] res;
    int lat;
    longint unsigned exp;
    exp = ref_mm(a, b, n);
    run_op(a, b, n, res, lat);
    check(res == exp[K-1:0], req, res, exp);
    check(lat <= 2 * K + 6, "R4 latency", lat, 2 * K + 6);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R7 done after reset", done, 0);
    check(result == '0, "R7 result after reset", result, 0);
  endtask

  task automatic t_directed();
    t_one(16'd5, 16'd7, 16'd11, "R1 small");
    t_one(16'd1, 16'd1, 16'd65535, "R1 unit operands");
    t_one(16'd40000, 16'd50000, 16'd65521, "R1 large");
    t_one(16'd12345, 16'd54321, 16'd60001, "R1 mixed");
  endtask

  task automatic t_edges();
    t_one(16'd0, 16'd1234, 16'd40001, "R6 A zero");
    t_one(16'd999, 16'd0, 16'd40001, "R6 B zero");
    t_one(16'd65534, 16'd65534, 16'd65535, "R6 A=B=N-1 max");
    t_one(16'd2, 16'd2, 16'd3, "R6 A=B=N-1 tiny");
    t_one(16'd30000, 16'd30000, 16'd30001, "R6 A=B=N-1 mid");
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) begin
      logic [K-1:0] n, a, b;
      n = K'($urandom) | 16'd1;
      if (n < 3) n = 16'd3;
      a = K'($urandom % n);
      b = K'($urandom % n);
      t_one(a, b, n, "R1 random");
    end
  endtask

  task automatic t_skip_latency();
    logic [K-1:0] moduli [3] = '{16'd3, 16'd4097, 16'd65535};
    foreach (moduli[i]) begin
      logic [K-1:0] res;
      int lat;
      run_op('0, '0, moduli[i], res, lat);
      check(res == '0, "R5 zero result", res, 0);
      check(lat <= K / 2 + 4, "R5 folded latency", lat, K / 2 + 4);
    end
  endtask

  task automatic t_ignore_start();
    logic [K-1:0] res;
    longint unsigned exp;
    int lat, extra;
    exp = ref_mm(16'd21845, 16'd13107, 16'd62003);
    @(negedge clk);
    a_in = 16'd21845; b_in = 16'd13107; n_in = 16'd62003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    a_in = 16'd7; b_in = 16'd9; n_in = 16'd13; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = result;
    check(res == exp[K-1:0], "R3 running op kept", res, exp);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R3 no second done", extra, 0);
    check(result == res, "R2 result held", result, res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_directed();
    t_edges();
    t_skip_latency();
    t_ignore_start();
    t_random();
    finish_run();
  end

endmodule